// File: doc/BRIEF.md
# Dual-Clock Latched Serial-to-Parallel Register

This block takes a serial bit stream into a chain of shift stages on one clock and copies the whole chain, in a single step, into a holding register on a second, independent clock. Once a full word has been shifted in, one pulse of the storage clock updates every parallel output bit together. The parallel bus does not show the individual shift steps. The holding register drives a parallel bus that floats to high impedance while the active-low output enable is high.

The last shift stage is also brought out on its own pin, so several instances can be chained into a longer register. An active-low asynchronous clear empties the shift chain at once. It leaves the holding register alone. When both clocks come from one net, each storage edge captures the chain as it stood before that edge's shift, so the parallel bus always trails the chain by one pulse.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising edge of `sh_clk` with `clr_n` high, stage 0 takes `ser_in` and every stage n+1 takes the old value of stage n.
- R2: `ser_out` always equals the last shift stage (stage WIDTH-1). It is driven whatever the level of `oe_n`.
- R3: On each rising edge of `st_clk`, every holding bit n takes shift stage n. Parallel bit n then shows holding bit n.
- R4: Between rising edges of `st_clk`, the holding register and the parallel bus do not change, however many shift edges occur.
- R5: When `sh_clk` and `st_clk` rise together, the holding register captures the chain value from before that edge's shift.
- R6: Driving `clr_n` low sets every shift stage to 0 at once, with no clock edge needed. While `clr_n` stays low, shift edges leave the stages at 0.
- R7: `clr_n` has no effect on the holding register or on the parallel bus.
- R8: While `oe_n` is low, `par_q` drives the holding register. While `oe_n` is high, every bit of `par_q` is high impedance.
- R9: With `ser_out` of one instance feeding `ser_in` of a second, 16 shift edges and then one storage edge place the first 8 bits shifted in on the second instance's bus and the last 8 bits on the first instance's bus, the most recent bit at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into shift stage 0 |
| sh_clk | input | 1 | Shift clock, rising edge active |
| st_clk | input | 1 | Storage clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| par_q | output | WIDTH | Tri-state parallel bus from the holding register |
| ser_out | output | 1 | Last shift stage, for cascading |

## Verification
Every shift or storage effect is due right after the one clock edge that causes it, because each path has a single register. The bench raises the clock and lets it fall. It samples two time units after the falling edge, well clear of the next rising edge. The clear and enable effects involve no register on their way to the outputs. For these, the bench samples one time unit after changing the pin, with no clock edge. Before it drives a clock, the bench model updates the holding copy from the pre-shift chain and only then shifts the chain, so a tied edge produces the lagging value on its own.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    localparam int unsigned DEF_WIDTH = 8;

    // Move every stage one place up and put the new bit in at the bottom.
    function automatic logic [DEF_WIDTH-1:0] advance(input logic [DEF_WIDTH-1:0] cur,
                                                     input logic              din);
        return {cur[DEF_WIDTH-2:0], din};
    endfunction

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned WIDTH = sipo_pkg::DEF_WIDTH
) (
    input  logic             sh_clk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stage
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] feed;
    assign feed = {stage[TOP-1:0], din};

    always_ff @(posedge sh_clk or negedge clr_n) begin
        if (!clr_n) stage <= '0;
        else        stage <= feed;
    end

    // R1: bottom stage takes the serial input
    assert_stage0_load_R1: assert property (@(posedge sh_clk) disable iff (!clr_n)
        1'b1 |=> stage[0] == $past(din));

    // R1: upper stages take their lower neighbour
    assert_stage_move_R1: assert property (@(posedge sh_clk) disable iff (!clr_n)
        1'b1 |=> stage[TOP:1] == $past(stage[TOP-1:0]));

    // R6: chain stays empty while the clear is held
    assert_clear_hold_R6: assert property (@(posedge sh_clk)
        !clr_n |-> stage == '0);

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
    parameter int unsigned WIDTH = sipo_pkg::DEF_WIDTH
) (
    input  logic             st_clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] snap,
    output logic [WIDTH-1:0] held
);

    always_ff @(posedge st_clk) begin
        held <= snap;
    end

    // R3: the holding register shows the chain seen at the previous storage edge
    assert_capture_R3: assert property (@(posedge st_clk) disable iff (!clr_n)
        1'b1 |=> held == $past(snap));

endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
    parameter int unsigned WIDTH = sipo_pkg::DEF_WIDTH
) (
    input  logic             ser_in,
    input  logic             sh_clk,
    input  logic             st_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_q,
    output logic             ser_out
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] chain;
    logic [WIDTH-1:0] held;

    sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .sh_clk (sh_clk),
        .clr_n  (clr_n),
        .din    (ser_in),
        .stage  (chain)
    );

    sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .st_clk (st_clk),
        .clr_n  (clr_n),
        .snap   (chain),
        .held   (held)
    );

    assign ser_out = chain[TOP];
    assign par_q   = oe_n ? {WIDTH{1'bz}} : held;

endmodule

// File: tb/sipo_latch_reg_test.sv
module sipo_latch_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic tck = 1'b0;
    always #(HALF) tck = ~tck;

    logic ser_in = 1'b0, sh_clk = 1'b0, st_clk = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
    logic ser_a, ser_b;
    wire [7:0] bus_a, bus_b;
    logic       probe_en = 1'b0;
    logic [7:0] probe_val = 8'h00;

    assign bus_a = probe_en ? probe_val : 8'bz;
    assign bus_b = probe_en ? probe_val : 8'bz;

    sipo_latch_reg #(.WIDTH(8)) uut (
        .ser_in(ser_in), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n),
        .oe_n(oe_n), .par_q(bus_a), .ser_out(ser_a)
    );

    sipo_latch_reg #(.WIDTH(8)) uut_tail (
        .ser_in(ser_a), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n),
        .oe_n(oe_n), .par_q(bus_b), .ser_out(ser_b)
    );

    int tests = 0;
    int fails = 0;

    // Bench model: 16-bit chain across both instances plus two holding copies.
    logic [15:0] chain_m = 16'h0000;
    logic [7:0]  stor_a  = 8'h00;
    logic [7:0]  stor_b  = 8'h00;

    function automatic logic [15:0] model_shift(input logic [15:0] c, input logic d);
        return {c[14:0], d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit do_sh, input bit do_st, input logic din);
        ser_in = din;
        #2;
        if (do_st) begin
            stor_a = chain_m[7:0];
            stor_b = chain_m[15:8];
        end
        if (do_sh && clr_n) chain_m = model_shift(chain_m, din);
        sh_clk = do_sh;
        st_clk = do_st;
        #(HALF);
        sh_clk = 1'b0;
        st_clk = 1'b0;
        #2;
    endtask

    task automatic check_outputs(input string req);
        chk(ser_a == chain_m[7], {req, " R2 ser_out first"}, {15'd0, ser_a}, {15'd0, chain_m[7]});
        chk(ser_b == chain_m[15], {req, " R9 ser_out tail"}, {15'd0, ser_b}, {15'd0, chain_m[15]});
        if (!oe_n) begin
            chk(bus_a == stor_a, {req, " R3 bus first"}, {8'd0, bus_a}, {8'd0, stor_a});
            chk(bus_b == stor_b, {req, " R9 bus tail"}, {8'd0, bus_b}, {8'd0, stor_b});
        end else begin
            probe_en  = 1'b1;
            probe_val = 8'h00;
            #1;
            chk(bus_a == 8'h00 && bus_b == 8'h00, "R8 float low probe", {bus_b, bus_a}, 16'h0000);
            probe_val = 8'hFF;
            #1;
            chk(bus_a == 8'hFF && bus_b == 8'hFF, "R8 float high probe", {bus_b, bus_a}, 16'hFFFF);
            probe_en = 1'b0;
            #1;
        end
    endtask

    task automatic shift_word(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(1'b1, 1'b0, w[i]);
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C3E_5A01));
        #3;
        // Reset state: clear without clock, then store the empty chain (R6)
        clr_n = 1'b0;
        chain_m = 16'h0000;
        #1;
        chk(ser_a == 1'b0 && ser_b == 1'b0, "R6 clear without clock", {14'd0, ser_b, ser_a}, 16'h0000);
        pulse(1'b0, 1'b1, 1'b0);
        clr_n = 1'b1;
        #1;
        check_outputs("reset");

        // R1 R3: load a byte, store it
        shift_word(16'h00A5, 8);
        check_outputs("R1 load");
        pulse(1'b0, 1'b1, 1'b0);
        chk(bus_a == 8'hA5, "R3 byte 0xA5", {8'd0, bus_a}, 16'h00A5);

        // R4: shifting alone leaves the bus as is
        shift_word(16'h0003, 3);
        chk(bus_a == 8'hA5, "R4 hold during shift", {8'd0, bus_a}, 16'h00A5);
        check_outputs("R4 hold");

        // R5: tied clocks capture the pre-shift chain
        for (int i = 0; i < 5; i++) begin
            pulse(1'b1, 1'b1, logic'(i[0]));
            check_outputs("R5 tied");
        end

        // R6 R7: clear during operation
        shift_word(16'h00FF, 8);
        pulse(1'b0, 1'b1, 1'b0);
        clr_n = 1'b0;
        chain_m = 16'h0000;
        #1;
        chk(ser_a == 1'b0, "R6 immediate clear", {15'd0, ser_a}, 16'h0000);
        chk(bus_a == stor_a, "R7 bus kept on clear", {8'd0, bus_a}, {8'd0, stor_a});
        pulse(1'b1, 1'b0, 1'b1);
        chk(ser_a == 1'b0, "R6 shift ignored while cleared", {15'd0, ser_a}, 16'h0000);
        chk(bus_a == 8'hFF, "R7 bus after clear", {8'd0, bus_a}, 16'h00FF);
        clr_n = 1'b1;
        #1;
        pulse(1'b0, 1'b1, 1'b0);
        chk(bus_a == 8'h00, "R6 chain empty after clear", {8'd0, bus_a}, 16'h0000);

        // R8 R2: enable high floats the bus, serial output still driven
        shift_word(16'h0081, 8);
        pulse(1'b0, 1'b1, 1'b0);
        oe_n = 1'b1;
        #1;
        check_outputs("R8 R2 disabled");
        pulse(1'b1, 1'b0, 1'b0);
        check_outputs("R8 R2 disabled shift");
        oe_n = 1'b0;
        #1;
        check_outputs("R8 enabled again");

        // R9: 16-bit cascade
        shift_word(16'hBEEF, 16);
        pulse(1'b0, 1'b1, 1'b0);
        chk({bus_b, bus_a} == 16'hBEEF, "R9 cascade word", {bus_b, bus_a}, 16'hBEEF);

        // Constrained random mix
        for (int k = 0; k < 300; k++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            if (op <= 4)      pulse(1'b1, 1'b0, logic'($urandom_range(0, 1)));
            else if (op <= 6) pulse(1'b0, 1'b1, 1'b0);
            else if (op == 7) pulse(1'b1, 1'b1, logic'($urandom_range(0, 1)));
            else if (op == 8) begin
                clr_n = 1'b0;
                chain_m = 16'h0000;
                #1;
                pulse(1'b1, 1'b0, 1'b1);
                clr_n = 1'b1;
                #1;
            end else begin
                oe_n = ~oe_n;
                #1;
            end
            check_outputs("R1 R4 R5 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule